// File: doc/BRIEF.md
# Pilot-Based Common Phase Error Tracker

This block sits after channel equalisation in an OFDM receiver. It takes one equalised frequency-domain subcarrier per stream beat, together with the carrier index, a flag that marks the carrier as a pilot, and the known sign of that pilot. A per-symbol allocation bit vector decides which carriers take part. Pilots that are enabled are multiplied by their known sign and summed. At the end of the symbol the sums are divided by the configured pilot count, which gives an estimate c + js of the symbol's residual common phase rotation.

Data carriers that are enabled are held in a symbol buffer while the estimate is formed. They are then streamed out, each multiplied by the conjugate of the estimate, so the correction always applies to the same symbol that produced it. Pilots and disabled carriers are not passed on. The pilot count can be changed at run time and need not be a power of two. Division uses a reciprocal table that is computed when the design is elaborated. Input is stalled while a symbol drains.

Top module: `pilot_cpe_tracker`

## Requirements
- R1: While reset is held and after it is released, out_valid and out_last are 0 and in_ready is 1.
- R2: A beat whose carrier has its latched allocation bit set and in_pilot=1 counts as a pilot. Its value is negated when in_pilot_neg=1 and then added to the symbol's real and imaginary sums.
- R3: At the end of the symbol the estimate is formed as c = floor(sum_re*K/65536) and s = floor(sum_im*K/65536), where K = floor((65536 + floor(np/2))/np) and np is the latched pilot count.
- R4: Only carriers with the allocation bit set and in_pilot=0 produce an output. Outputs keep arrival order and carry the carrier index. Pilots and disabled carriers produce nothing.
- R5: Each output a+jb becomes out_re = floor((a*c + b*s)/2048) and out_im = floor((b*c - a*s)/2048).
- R6: out_last is 1 only on the final output of a symbol. A symbol with no enabled data carrier produces no output at all.
- R7: in_ready drops in the cycle after the beat with in_last=1 is accepted. It stays low until that symbol's outputs are done, and outputs appear only while input is stalled or in the cycle right after.
- R8: cfg_alloc and cfg_np are sampled only on the first beat of a symbol. Changes to them later in the symbol have no effect on that symbol.
- R9: The pilot count is a run-time value from 1 to 255 and is not limited to powers of two (for example 3, 4, 240).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts a beat |
| in_idx | input | 8 | Carrier index |
| in_re | input | 12 | Equalised carrier, real part (signed) |
| in_im | input | 12 | Equalised carrier, imaginary part (signed) |
| in_pilot | input | 1 | Carrier is a pilot |
| in_pilot_neg | input | 1 | Known pilot value is -1 (0 means +1) |
| in_last | input | 1 | Final beat of the symbol |
| cfg_alloc | input | 256 | Allocation bit per carrier index |
| cfg_np | input | 8 | Number of enabled pilots in the symbol |
| out_valid | output | 1 | Corrected carrier valid |
| out_idx | output | 8 | Carrier index of the output |
| out_re | output | 15 | Corrected real part (signed) |
| out_im | output | 15 | Corrected imaginary part (signed) |
| out_last | output | 1 | Final corrected carrier of the symbol |

## Verification
The assertions assume that the count of enabled pilots in each symbol equals the cfg_np value sampled on its first beat. They also assume that the sender stops after in_last until in_ready returns. The stimulus generator derives cfg_np from the pilots it actually enables, and it forces at least one enabled pilot into every symbol. Inside a symbol it uses distinct indices in ascending order, and between symbols it waits for in_ready. When the bench changes the configuration mid-symbol, the latched values still match the symbol's real pilot count.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  localparam int RECIP_BITS = 16;

  typedef enum logic [1:0] {ST_COLLECT, ST_EST, ST_DRAIN} cpe_state_e;

  // rounded reciprocal of the pilot count, scaled by 2^RECIP_BITS
  function automatic logic [RECIP_BITS:0] recip_of(input int np);
    int r;
    if (np <= 0) r = 0;
    else r = ((1 << RECIP_BITS) + (np / 2)) / np;
    return (RECIP_BITS+1)'(r);
  endfunction

  // mean of a pilot sum using the stored reciprocal
  function automatic logic signed [47:0] mean_of(input logic signed [31:0] sum,
                                                 input logic [RECIP_BITS:0] k);
    logic signed [47:0] p;
    p = 48'(sum) * $signed(48'({1'b0, k}));
    return p >>> RECIP_BITS;
  endfunction

  // real part of (a+jb)*(c-js) with scaling
  function automatic logic signed [47:0] rot_re(input logic signed [31:0] a, input logic signed [31:0] b,
                                                input logic signed [31:0] c, input logic signed [31:0] s,
                                                input int sh);
    logic signed [47:0] t;
    t = 48'(a) * 48'(c) + 48'(b) * 48'(s);
    return t >>> sh;
  endfunction

  // imaginary part of (a+jb)*(c-js) with scaling
  function automatic logic signed [47:0] rot_im(input logic signed [31:0] a, input logic signed [31:0] b,
                                                input logic signed [31:0] c, input logic signed [31:0] s,
                                                input int sh);
    logic signed [47:0] t;
    t = 48'(b) * 48'(c) - 48'(a) * 48'(s);
    return t >>> sh;
  endfunction
endpackage

// File: rtl/cpe_pilot_acc.sv
module cpe_pilot_acc #(
  parameter int DW  = 12,
  parameter int NPW = 8,
  localparam int SW = DW + NPW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 take,
  input  logic                 neg,
  input  logic signed [DW-1:0] re,
  input  logic signed [DW-1:0] im,
  output logic signed [SW-1:0] sum_re,
  output logic signed [SW-1:0] sum_im,
  output logic [NPW:0]         cnt
);
  logic signed [SW-1:0] ext_re, ext_im;

  always_comb begin
    ext_re = SW'(re);
    ext_im = SW'(im);
    if (neg) begin
      ext_re = -ext_re;
      ext_im = -ext_im;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sum_re <= '0;
      sum_im <= '0;
      cnt    <= '0;
    end else if (take) begin
      sum_re <= sum_re + ext_re;
      sum_im <= sum_im + ext_im;
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cpe_sym_buf.sv
module cpe_sym_buf #(
  parameter int DEPTH = 256,
  parameter int EW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cpe_derotate.sv
module cpe_derotate #(
  parameter int DW = 12,
  parameter int IW = 8,
  localparam int EW = DW + 1,
  localparam int OW = DW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic                 last,
  input  logic [IW-1:0]        idx,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic signed [EW-1:0] c,
  input  logic signed [EW-1:0] s,
  output logic                 out_valid,
  output logic                 out_last,
  output logic [IW-1:0]        out_idx,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);
  import cpe_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= fire;
      out_last  <= fire && last;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      out_idx <= idx;
      out_re  <= OW'(rot_re(32'(a), 32'(b), 32'(c), 32'(s), DW - 1));
      out_im  <= OW'(rot_im(32'(a), 32'(b), 32'(c), 32'(s), DW - 1));
    end
  end
endmodule

// File: rtl/pilot_cpe_tracker.sv
module pilot_cpe_tracker #(
  parameter int DW   = 12,
  parameter int NMAX = 256,
  parameter int NPW  = 8,
  localparam int IW  = $clog2(NMAX),
  localparam int SW  = DW + NPW + 1,
  localparam int EW  = DW + 1,
  localparam int OW  = DW + 3,
  localparam int BW  = IW + 2 * DW,
  localparam int NPN = 1 << NPW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IW-1:0]        in_idx,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic                 in_pilot,
  input  logic                 in_pilot_neg,
  input  logic                 in_last,
  input  logic [NMAX-1:0]      cfg_alloc,
  input  logic [NPW-1:0]       cfg_np,
  output logic                 out_valid,
  output logic [IW-1:0]        out_idx,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im,
  output logic                 out_last
);
  import cpe_pkg::*;

  cpe_state_e state;
  logic [IW:0]       wr_cnt, rd_ptr;
  logic [NMAX-1:0]   alloc_q, alloc_use;
  logic [NPW-1:0]    np_q;
  logic              first_q;
  logic signed [EW-1:0] est_c, est_s;

  // named events for the checker
  logic beat_acc, cfg_load, hit, pilot_take, data_take, sym_end, est_evt, drain_fire, rd_last;

  logic [RECIP_BITS:0] recip_rom [NPN];
  for (genvar g = 0; g < NPN; g++) begin : g_recip
    assign recip_rom[g] = recip_of(g);
  end

  assign in_ready   = (state == ST_COLLECT);
  assign beat_acc   = in_valid && in_ready;
  assign cfg_load   = beat_acc && first_q;
  assign alloc_use  = cfg_load ? cfg_alloc : alloc_q;
  assign hit        = alloc_use[in_idx];
  assign pilot_take = beat_acc && hit && in_pilot;
  assign data_take  = beat_acc && hit && !in_pilot;
  assign sym_end    = beat_acc && in_last;
  assign est_evt    = (state == ST_EST);
  assign drain_fire = (state == ST_DRAIN);
  assign rd_last    = (rd_ptr + (IW+1)'(1)) == wr_cnt;

  logic signed [SW-1:0] sum_re, sum_im;
  logic [NPW:0]         pilot_cnt;

  cpe_pilot_acc #(.DW(DW), .NPW(NPW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(est_evt), .take(pilot_take), .neg(in_pilot_neg),
    .re(in_re), .im(in_im), .sum_re(sum_re), .sum_im(sum_im), .cnt(pilot_cnt)
  );

  logic [BW-1:0] buf_rd;
  cpe_sym_buf #(.DEPTH(NMAX), .EW(BW)) u_buf (
    .clk(clk), .we(data_take), .waddr(wr_cnt[IW-1:0]), .wdata({in_idx, in_re, in_im}),
    .raddr(rd_ptr[IW-1:0]), .rdata(buf_rd)
  );

  cpe_derotate #(.DW(DW), .IW(IW)) u_rot (
    .clk(clk), .rst_n(rst_n), .fire(drain_fire), .last(rd_last),
    .idx(buf_rd[BW-1 -: IW]), .a(buf_rd[2*DW-1 -: DW]), .b(buf_rd[DW-1:0]),
    .c(est_c), .s(est_s),
    .out_valid(out_valid), .out_last(out_last), .out_idx(out_idx),
    .out_re(out_re), .out_im(out_im)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_COLLECT;
      wr_cnt  <= '0;
      rd_ptr  <= '0;
      first_q <= 1'b1;
      alloc_q <= '0;
      np_q    <= '0;
      est_c   <= '0;
      est_s   <= '0;
    end else begin
      if (cfg_load) begin
        alloc_q <= cfg_alloc;
        np_q    <= cfg_np;
      end
      if (beat_acc) first_q <= in_last;
      if (data_take) wr_cnt <= wr_cnt + 1'b1;
      unique case (state)
        ST_COLLECT: if (sym_end) state <= ST_EST;
        ST_EST: begin
          est_c  <= EW'(mean_of(32'(sum_re), recip_rom[np_q]));
          est_s  <= EW'(mean_of(32'(sum_im), recip_rom[np_q]));
          rd_ptr <= '0;
          state  <= (wr_cnt == '0) ? ST_COLLECT : ST_DRAIN;
        end
        ST_DRAIN: begin
          rd_ptr <= rd_ptr + 1'b1;
          if (rd_last) begin
            state  <= ST_COLLECT;
            wr_cnt <= '0;
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/cpe_tracker_checker.sv
module cpe_tracker_checker #(
  parameter int NPW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           in_last,
  input logic           out_valid,
  input logic           out_last,
  input logic           cfg_load,
  input logic           est_evt,
  input logic [NPW-1:0] np_q,
  input logic [NPW:0]   pilot_cnt
);
  p_last_has_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid && in_last));

  p_out_after_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!in_ready));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(np_q) |-> $past(cfg_load));

  p_pilot_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    est_evt |-> (pilot_cnt == {1'b0, np_q}));

  p_nonzero_np_r9: assert property (@(posedge clk) disable iff (!rst_n)
    est_evt |-> (np_q != '0));
endmodule

bind pilot_cpe_tracker cpe_tracker_checker #(.NPW(NPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
  .out_valid(out_valid), .out_last(out_last), .cfg_load(cfg_load), .est_evt(est_evt),
  .np_q(np_q), .pilot_cnt(pilot_cnt)
);

// File: tb/pilot_cpe_tracker_tb.sv
module pilot_cpe_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_pilot = 1'b0, in_pilot_neg = 1'b0, in_last = 1'b0;
  logic [7:0] in_idx = '0;
  logic signed [11:0] in_re = '0, in_im = '0;
  logic [N-1:0] cfg_alloc = '0;
  logic [7:0] cfg_np = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_idx;
  logic signed [14:0] out_re, out_im;

  always #(CLK_PERIOD/2) clk = ~clk;

  pilot_cpe_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
    .in_re(in_re), .in_im(in_im), .in_pilot(in_pilot), .in_pilot_neg(in_pilot_neg),
    .in_last(in_last), .cfg_alloc(cfg_alloc), .cfg_np(cfg_np), .out_valid(out_valid),
    .out_idx(out_idx), .out_re(out_re), .out_im(out_im), .out_last(out_last)
  );

  int n_cmp = 0, n_bad = 0;
  int s_n, s_np;
  int s_re [N], s_im [N];
  bit s_pil [N], s_neg [N];
  logic [N-1:0] s_alloc;
  int g_idx[$], g_re[$], g_im[$], g_last[$];

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      g_idx.push_back(int'(out_idx));
      g_re.push_back(int'(out_re));
      g_im.push_back(int'(out_im));
      g_last.push_back(int'(out_last));
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint fdiv(input longint x, input longint d);
    longint q;
    q = x / d;
    if ((x % d != 0) && (x < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int rnd_val();
    return int'($urandom_range(4094)) - 2047;
  endfunction

  task automatic gen_random(input int n, input int pil_pct, input int off_pct);
    s_n = n;
    s_np = 0;
    for (int k = 0; k < n; k++) begin
      s_re[k] = rnd_val();
      s_im[k] = rnd_val();
      s_pil[k] = ($urandom_range(99) < pil_pct);
      s_neg[k] = $urandom_range(1);
      s_alloc[k] = ($urandom_range(99) >= off_pct);
    end
    for (int k = n; k < N; k++) s_alloc[k] = $urandom_range(1);
    s_pil[0] = 1'b1;
    s_alloc[0] = 1'b1;
    for (int k = 0; k < n; k++) if (s_alloc[k] && s_pil[k]) s_np++;
  endtask

  task automatic run_symbol(input bit mid_change, input string tag);
    longint sr, si, kk, c, s, a, b;
    int j;
    g_idx.delete(); g_re.delete(); g_im.delete(); g_last.delete();
    for (int k = 0; k < s_n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_idx = 8'(k);
      in_re = 12'(s_re[k]);
      in_im = 12'(s_im[k]);
      in_pilot = s_pil[k];
      in_pilot_neg = s_neg[k];
      in_last = (k == s_n - 1);
      if (k == 0 || !mid_change) begin
        cfg_alloc = s_alloc;
        cfg_np = 8'(s_np);
      end else begin
        cfg_alloc = ~s_alloc;
        cfg_np = 8'(s_np + 1);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    chk(in_ready == 1'b0, {"R7 stall ", tag}, in_ready, 0);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    // expected values
    sr = 0; si = 0;
    for (int k = 0; k < s_n; k++)
      if (s_alloc[k] && s_pil[k]) begin
        sr += s_neg[k] ? -s_re[k] : s_re[k];
        si += s_neg[k] ? -s_im[k] : s_im[k];
      end
    kk = (65536 + s_np / 2) / s_np;
    c = fdiv(sr * kk, 65536);
    s = fdiv(si * kk, 65536);
    j = 0;
    for (int k = 0; k < s_n; k++) begin
      if (s_alloc[k] && !s_pil[k]) begin
        if (j < g_idx.size()) begin
          a = s_re[k]; b = s_im[k];
          chk(g_idx[j] == k, {"R4 index ", tag}, g_idx[j], k);
          chk(g_re[j] == fdiv(a * c + b * s, 2048), {"R5 R3 R2 real ", tag}, g_re[j], fdiv(a * c + b * s, 2048));
          chk(g_im[j] == fdiv(b * c - a * s, 2048), {"R5 R3 R2 imag ", tag}, g_im[j], fdiv(b * c - a * s, 2048));
          chk(g_last[j] == ((j + 1 == g_idx.size()) ? 1 : 0), {"R6 last flag ", tag}, g_last[j], (j + 1 == g_idx.size()));
        end
        j++;
      end
    end
    chk(g_idx.size() == j, {"R4 R6 output count ", tag}, g_idx.size(), j);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_last == 1'b0, "R1 outputs after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

    // four pilots, all carriers enabled
    s_n = 16; s_np = 0; s_alloc = '1;
    for (int k = 0; k < 16; k++) begin
      s_pil[k] = (k % 4 == 1); s_neg[k] = (k == 5 || k == 13);
      s_re[k] = (k % 4 == 1) ? (s_neg[k] ? -1900 : 1900) : rnd_val();
      s_im[k] = (k % 4 == 1) ? (s_neg[k] ? -300 : 300) : rnd_val();
      if (s_pil[k]) s_np++;
    end
    run_symbol(1'b0, "np4");

    // 240 pilots over a full 256-carrier symbol
    s_n = 256; s_np = 0; s_alloc = '1;
    for (int k = 0; k < 256; k++) begin
      s_pil[k] = (k % 16 != 7); s_neg[k] = $urandom_range(1);
      s_re[k] = rnd_val(); s_im[k] = rnd_val();
      if (s_pil[k]) s_np++;
    end
    run_symbol(1'b0, "R9 np240");

    // three pilots, non-power-of-two
    s_n = 12; s_np = 0; s_alloc = '1;
    for (int k = 0; k < 12; k++) begin
      s_pil[k] = (k == 2 || k == 6 || k == 9); s_neg[k] = (k == 6);
      s_re[k] = (k % 2 == 0) ? -2047 : 2047; s_im[k] = (k % 3 == 0) ? -2047 : 2047;
      if (s_pil[k]) s_np++;
    end
    run_symbol(1'b0, "R9 np3 extremes");

    // all pilots: no output expected
    s_n = 8; s_np = 8; s_alloc = '1;
    for (int k = 0; k < 8; k++) begin
      s_pil[k] = 1'b1; s_neg[k] = k[0]; s_re[k] = rnd_val(); s_im[k] = rnd_val();
    end
    run_symbol(1'b0, "R6 empty");

    // configuration changed mid-symbol
    gen_random(40, 20, 30);
    run_symbol(1'b1, "R8 mid change");

    // disabled carriers and random mixes
    for (int t = 0; t < 12; t++) begin
      gen_random(8 + int'($urandom_range(120)), 25, 35);
      run_symbol(t % 3 == 0, "R4 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule